// File: doc/BRIEF.md
# Gshare Direction Predictor with Stuck-at Cell Faults

This block predicts the direction of conditional branches. It hashes the branch address with a global history of recent outcomes to pick one 2-bit saturating counter. The upper bit of that counter is the prediction. When a branch resolves, the pipeline returns the table index it was given and the real outcome. The counter then moves one step toward that outcome, and the outcome shifts into the history.

Every counter cell sits behind a stuck-at overlay. A loadable fault map marks each cell of an entry as healthy or as stuck, and a stuck cell is fixed at 0 or 1. Reads see the forced values. Updates also store through the overlay. A stuck direction bit therefore turns its entry into a fixed always-taken or always-not-taken predictor. A stuck low bit can pin the counter inside one half of its range. Clearing a fault exposes the value that was last stored, and that stored value already carries the forced bits. The table holds 2^IDX_W entries, so a 32K-entry table uses IDX_W = 15. The history register is IDX_W bits wide.

Top module: `gshare_fault_pred`

## Requirements
- R1: The lookup index is `lookup_pc_i[PC_LSB +: IDX_W]` XOR the global history value that `ghist_o` shows in the lookup cycle.
- R2: `pred_valid_o` is high in exactly the cycle after a cycle with `lookup_valid_i` high. In that cycle `pred_idx_o` carries the index used by that lookup.
- R3: `pred_taken_o` equals bit 1 (the direction bit) of the entry's effective counter while `pred_valid_o` is high. It is 0 while `pred_valid_o` is low.
- R4: After reset, every stored counter is 2'b01 (weakly not-taken), the history is zero, the fault map is clear, and `pred_valid_o` is low.
- R5: On an update, a taken outcome raises the effective counter by one and stops at 3. A not-taken outcome lowers it by one and stops at 0.
- R6: On an update, the history shifts left by one and the outcome enters bit 0 (1 = taken). With no update, the history holds.
- R7: A write to the fault map (`fault_we_i`) replaces that entry's fault setting. In `fault_mask_i`, bit 1 stands for the direction cell and bit 0 for the low cell. A mask bit of 1 sticks that cell at the matching bit of `fault_val_i`, and a mask of 0 clears the entry's faults.
- R8: An entry whose direction cell is stuck predicts the stuck value whatever updates it receives.
- R9: The update result is stored through the overlay, so stuck cells hold their forced values in storage. With the low cell stuck at 0, an entry starting from reset never predicts taken. After that fault is cleared, the entry resumes from the forced value that was stored.
- R10: If a lookup and an update happen in the same cycle, the lookup sees the counter state and history from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_pc_i | input | PC_W | Branch address for the lookup |
| pred_valid_o | output | 1 | Prediction valid, one cycle after the request |
| pred_taken_o | output | 1 | Predicted direction (1 = taken) |
| pred_idx_o | output | IDX_W | Table index used by the prediction |
| upd_valid_i | input | 1 | Resolution update |
| upd_idx_i | input | IDX_W | Index returned from the prediction |
| upd_taken_i | input | 1 | Resolved outcome (1 = taken) |
| fault_we_i | input | 1 | Fault map write |
| fault_idx_i | input | IDX_W | Entry whose fault setting is written |
| fault_mask_i | input | 2 | Stuck cells of the entry (bit 1 direction, bit 0 low) |
| fault_val_i | input | 2 | Forced values of the stuck cells |
| ghist_o | output | IDX_W | Current global history |

## Verification
The bench builds the block with IDX_W = 6, PC_W = 16 and PC_LSB = 2, which gives a 64-entry table and a 6-bit history. The bench follows the history itself and computes lookup addresses so that each lookup lands on a chosen entry. This lets it train a single counter through both saturation points, place faults on chosen entries, and then clear them. With a table this small, the same-cycle lookup and update case and the behaviour after a fault is cleared can both be reached in a few dozen cycles.

// File: rtl/gshare_fault_pkg.sv
package gshare_fault_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;

  function automatic ctr_t apply_faults(ctr_t raw, ctr_t mask, ctr_t val);
    return (raw & ~mask) | (val & mask);
  endfunction
endpackage

// File: rtl/gshare_hash.sv
module gshare_hash #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int PC_LSB = 2
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [IDX_W-1:0] hist_i,
  output logic [IDX_W-1:0] idx_o
);
  assign idx_o = pc_i[PC_LSB +: IDX_W] ^ hist_i;
endmodule

// File: rtl/gshare_ctr_step.sv
module gshare_ctr_step
  import gshare_fault_pkg::*;
(
  input  ctr_t ctr_i,
  input  logic taken_i,
  output ctr_t ctr_o
);
  always_comb begin
    ctr_o = ctr_i;
    if (taken_i && ctr_i != 2'b11) ctr_o = ctr_i + 2'b01;
    else if (!taken_i && ctr_i != 2'b00) ctr_o = ctr_i - 2'b01;
  end
endmodule

// File: rtl/gshare_ghist.sv
module gshare_ghist #(
  parameter int HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], bit_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/gshare_table.sv
module gshare_table
  import gshare_fault_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output ctr_t             rd_a_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output ctr_t             rd_b_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  ctr_t             wr_ctr_i,
  input  logic             flt_we_i,
  input  logic [IDX_W-1:0] flt_idx_i,
  input  ctr_t             flt_mask_i,
  input  ctr_t             flt_val_i
);
  ctr_t eff [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    ctr_t ctr_q, fmask_q, fval_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctr_q   <= CTR_RESET;
        fmask_q <= '0;
        fval_q  <= '0;
      end else begin
        // store through the overlay: stuck cells keep their forced value
        if (wr_en_i && wr_idx_i == IDX_W'(e))
          ctr_q <= apply_faults(wr_ctr_i, fmask_q, fval_q);
        if (flt_we_i && flt_idx_i == IDX_W'(e)) begin
          fmask_q <= flt_mask_i;
          fval_q  <= flt_val_i;
        end
      end
    end

    assign eff[e] = apply_faults(ctr_q, fmask_q, fval_q);
  end

  assign rd_a_o = eff[rd_a_idx_i];
  assign rd_b_o = eff[rd_b_idx_i];
endmodule

// File: rtl/gshare_fault_pred.sv
module gshare_fault_pred
  import gshare_fault_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int PC_LSB = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_valid_i,
  input  logic [PC_W-1:0]  lookup_pc_i,
  output logic             pred_valid_o,
  output logic             pred_taken_o,
  output logic [IDX_W-1:0] pred_idx_o,
  input  logic             upd_valid_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_taken_i,
  input  logic             fault_we_i,
  input  logic [IDX_W-1:0] fault_idx_i,
  input  logic [1:0]       fault_mask_i,
  input  logic [1:0]       fault_val_i,
  output logic [IDX_W-1:0] ghist_o
);
  localparam int HIST_W = IDX_W;

  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  lk_idx;
  ctr_t              lk_ctr, up_ctr, up_next;

  logic              pred_valid_q, pred_taken_q;
  logic [IDX_W-1:0]  pred_idx_q;

  gshare_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB)) u_hash (
    .pc_i   (lookup_pc_i),
    .hist_i (hist),
    .idx_o  (lk_idx)
  );

  gshare_table #(.IDX_W(IDX_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_a_idx_i (lk_idx),
    .rd_a_o     (lk_ctr),
    .rd_b_idx_i (upd_idx_i),
    .rd_b_o     (up_ctr),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_idx_i),
    .wr_ctr_i   (up_next),
    .flt_we_i   (fault_we_i),
    .flt_idx_i  (fault_idx_i),
    .flt_mask_i (fault_mask_i),
    .flt_val_i  (fault_val_i)
  );

  gshare_ctr_step u_step (
    .ctr_i   (up_ctr),
    .taken_i (upd_taken_i),
    .ctr_o   (up_next)
  );

  gshare_ghist #(.HIST_W(HIST_W)) u_ghist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (upd_valid_i),
    .bit_i   (upd_taken_i),
    .hist_o  (hist)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_q <= 1'b0;
      pred_taken_q <= 1'b0;
      pred_idx_q   <= '0;
    end else begin
      pred_valid_q <= lookup_valid_i;
      pred_taken_q <= lookup_valid_i & lk_ctr[1];
      if (lookup_valid_i) pred_idx_q <= lk_idx;
    end
  end

  assign pred_valid_o = pred_valid_q;
  assign pred_taken_o = pred_taken_q;
  assign pred_idx_o   = pred_idx_q;
  assign ghist_o      = hist;
endmodule

// File: rtl/gshare_fault_pred_chk.sv
module gshare_fault_pred_chk #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int PC_LSB = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lookup_valid_i,
  input logic [PC_W-1:0]  lookup_pc_i,
  input logic             pred_valid_o,
  input logic             pred_taken_o,
  input logic [IDX_W-1:0] pred_idx_o,
  input logic             upd_valid_i,
  input logic             upd_taken_i,
  input logic [IDX_W-1:0] ghist_o
);
  AST_PRED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> pred_valid_o); // R2
  AST_PRED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> !pred_valid_o); // R2
  AST_IDX_HASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> pred_idx_o == ($past(lookup_pc_i[PC_LSB +: IDX_W]) ^ $past(ghist_o))); // R1
  AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> ghist_o == {$past(ghist_o[IDX_W-2:0]), $past(upd_taken_i)}); // R6
  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghist_o)); // R6
  AST_QUIET_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_o |-> !pred_taken_o); // R3
endmodule

bind gshare_fault_pred gshare_fault_pred_chk #(
  .PC_W(PC_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_valid_i (lookup_valid_i),
  .lookup_pc_i    (lookup_pc_i),
  .pred_valid_o   (pred_valid_o),
  .pred_taken_o   (pred_taken_o),
  .pred_idx_o     (pred_idx_o),
  .upd_valid_i    (upd_valid_i),
  .upd_taken_i    (upd_taken_i),
  .ghist_o        (ghist_o)
);

// File: tb/gshare_fault_pred_bench.sv
module gshare_fault_pred_bench;
  localparam int PC_W = 16, IW = 6, LSB = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_v = 1'b0, up_v = 1'b0, up_t = 1'b0, f_we = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic [IW-1:0] up_idx = '0, f_idx = '0, p_idx, ghist;
  logic [1:0] f_mask = '0, f_val = '0;
  logic p_v, p_t;

  int checks = 0, fails = 0;
  logic [IW-1:0] hist_m = '0;
  bit done = 0;

  always #10 clk = ~clk;

  gshare_fault_pred #(.PC_W(PC_W), .IDX_W(IW), .PC_LSB(LSB)) u_gshare_fault_pred (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_valid_i(lk_v), .lookup_pc_i(lk_pc),
    .pred_valid_o(p_v), .pred_taken_o(p_t), .pred_idx_o(p_idx),
    .upd_valid_i(up_v), .upd_idx_i(up_idx), .upd_taken_i(up_t),
    .fault_we_i(f_we), .fault_idx_i(f_idx), .fault_mask_i(f_mask), .fault_val_i(f_val),
    .ghist_o(ghist)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] pc_for(input logic [IW-1:0] idx);
    return PC_W'(idx ^ hist_m) << LSB;
  endfunction

  // lookup at a chosen entry; check index and direction one cycle later
  task automatic lookup(input logic [IW-1:0] idx, input logic exp_t, input string req);
    @(negedge clk);
    lk_v = 1'b1; lk_pc = pc_for(idx);
    @(negedge clk);
    lk_v = 1'b0;
    check({req, " valid"}, p_v, 1'b1);
    check({req, " idx"}, p_idx, idx);
    check({req, " taken"}, p_t, exp_t);
  endtask

  task automatic update(input logic [IW-1:0] idx, input logic t);
    @(negedge clk);
    up_v = 1'b1; up_idx = idx; up_t = t;
    @(negedge clk);
    up_v = 1'b0;
    hist_m = {hist_m[IW-2:0], t};
    check("R6 history", ghist, hist_m);
  endtask

  task automatic load_fault(input logic [IW-1:0] idx, input logic [1:0] m, input logic [1:0] v);
    @(negedge clk);
    f_we = 1'b1; f_idx = idx; f_mask = m; f_val = v;
    @(negedge clk);
    f_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R4 pred_valid", p_v, 1'b0);
    check("R3 taken low when idle", p_t, 1'b0);
    check("R4 history", ghist, '0);
    lookup(6'd5, 1'b0, "R4 R2 reset counter");
    @(negedge clk);
    check("R2 valid drops", p_v, 1'b0);
  endtask

  task automatic t_saturate();
    logic [IW-1:0] e = 6'd10;
    update(e, 1'b1); lookup(e, 1'b1, "R5 01->10");
    update(e, 1'b1); update(e, 1'b1); update(e, 1'b1);
    update(e, 1'b0); lookup(e, 1'b1, "R5 sat 3 then 10");
    update(e, 1'b0); lookup(e, 1'b0, "R5 01");
    update(e, 1'b0); update(e, 1'b0); update(e, 1'b0);
    update(e, 1'b1); lookup(e, 1'b0, "R5 sat 0 then 01");
    update(e, 1'b1); lookup(e, 1'b1, "R5 10");
  endtask

  task automatic t_hist();
    logic [IW-1:0] h = hist_m;
    repeat (3) @(negedge clk);
    check("R6 hold", ghist, h);
    lookup(6'd33, 1'b0, "R1 hashed index");
  endtask

  task automatic t_stuck_dir();
    load_fault(6'd20, 2'b10, 2'b10);
    lookup(6'd20, 1'b1, "R7 R8 dir stuck 1");
    repeat (4) update(6'd20, 1'b0);
    lookup(6'd20, 1'b1, "R8 stuck 1 after not-taken");
    update(6'd21, 1'b1); update(6'd21, 1'b1);
    lookup(6'd21, 1'b1, "R5 trained 21");
    load_fault(6'd21, 2'b10, 2'b00);
    lookup(6'd21, 1'b0, "R8 dir stuck 0");
    update(6'd21, 1'b1);
    lookup(6'd21, 1'b0, "R8 stuck 0 after taken");
  endtask

  task automatic t_stuck_low();
    load_fault(6'd30, 2'b01, 2'b00);
    repeat (3) update(6'd30, 1'b1);
    lookup(6'd30, 1'b0, "R9 low stuck 0 never taken");
    load_fault(6'd30, 2'b00, 2'b11);
    update(6'd30, 1'b1);
    lookup(6'd30, 1'b0, "R9 R7 cleared resumes from 00");
    update(6'd30, 1'b1);
    lookup(6'd30, 1'b1, "R7 cleared reaches 10");
  endtask

  task automatic t_same_cycle();
    logic [IW-1:0] e = 6'd40;
    @(negedge clk);
    lk_v = 1'b1; lk_pc = pc_for(e);
    up_v = 1'b1; up_idx = e; up_t = 1'b1;
    @(negedge clk);
    lk_v = 1'b0; up_v = 1'b0;
    hist_m = {hist_m[IW-2:0], 1'b1};
    check("R10 idx pre-update history", p_idx, e);
    check("R10 taken pre-update", p_t, 1'b0);
    lookup(e, 1'b1, "R10 update landed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_saturate();
    t_hist();
    t_stuck_dir();
    t_stuck_low();
    t_same_cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule